// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a timebase tick into a periodic interrupt and a square wave for a real-time-clock style register set. A free-running divider counts timebase ticks. A four-bit rate code picks one divider stage, and that stage raises the periodic flag once per period. A divisor code picks the timebase. One timebase changes the meaning of the two fastest rate codes, and two other divisor codes stop the divider and hold it at zero.

The block also keeps the status flags: the periodic flag, an alarm flag and an update-ended flag. It forms the combined interrupt-request flag and the active-low interrupt pin from those flags and their enables. A one-cycle status read strobe returns the status byte and clears every flag at the clock edge that ends the read. The timebase tick is one system-clock cycle wide and stands for a 32768 Hz source. The 4 MHz and 1 MHz selections feed the same internal stage as that source.

Top module: `rtc_pirq_gen`

## Requirements
- R1: While reset is low and after it is released, all flags are clear, `irq_n` is 1, `sqw` is 0 and the divider count is zero.
- R2: For rate codes 3 to 15, the periodic flag is set on the tick that completes each run of 2^(code-1) ticks of the divider. It is visible in the cycle after that tick and is set whatever the periodic enable is.
- R3: When the divisor code is 3'b010 (slow timebase), rate codes 1 and 2 give periods of 128 and 256 ticks. With any other running divisor code they give periods of 1 and 2 ticks.
- R4: Rate code 0 never sets the periodic flag and keeps `sqw` at 0.
- R5: Divisor codes 3'b110 and 3'b111 hold the divider count at zero, produce no periodic events and keep `sqw` at 0. After release, the first event comes a full period of ticks later.
- R6: `stat_q` is the status byte: bit 7 is the interrupt-request flag, bit 6 the periodic flag, bit 5 the alarm flag, bit 4 the update flag, and bits 3:0 are 0.
- R7: A cycle with `stat_rd` high clears all flags at its closing edge. An event in that same cycle sets its flag anyway.
- R8: `irq_flag` is high whenever a flag is set together with its enable (periodic with `pie_en`, alarm with `aie_en`, update with `uie_en`). `irq_n` is its inverse.
- R9: With `sqw_en` high, `sqw` is a square wave at the periodic rate. It is high in the second half of each period and falls on the tick that raises the periodic event. For a one-tick period it toggles on every tick.
- R10: `alarm_evt` and `update_evt` pulses set the alarm and update flags whatever their enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | One-cycle timebase tick |
| rate_sel | input | 4 | Periodic rate code |
| div_sel | input | 3 | Divisor (timebase) code |
| pie_en | input | 1 | Periodic interrupt enable |
| aie_en | input | 1 | Alarm interrupt enable |
| uie_en | input | 1 | Update interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | One-cycle alarm event |
| update_evt | input | 1 | One-cycle update-ended event |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_q | output | 8 | Status byte |
| per_flag | output | 1 | Periodic flag |
| irq_flag | output | 1 | Combined interrupt-request flag |
| irq_n | output | 1 | Active-low interrupt pin |
| sqw | output | 1 | Square-wave output |

## Verification
The assertions assume that `tb_tick`, `alarm_evt`, `update_evt` and `stat_rd` are synchronous to `clk`. They also assume that control fields change only between edges, so that a rise of the periodic flag can be traced to a tick in the cycle before it. The stimulus drives every input a few nanoseconds after the rising edge. Ticks arrive every cycle, every third cycle or at random cycles. Rate, divisor and enable changes land on arbitrary cycles, including cycles with a read or an event, and the reference model is stepped from the same sampled values.

// File: rtl/rtc_pirq_gen.sv
module rtc_pirq_gen #(
  parameter int CNT_W = 15,
  parameter int RATE_W = 4,
  parameter int DIV_W = 3,
  parameter logic [DIV_W-1:0] DIV_SLOW = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              pie_en,
  input  logic              aie_en,
  input  logic              uie_en,
  input  logic              sqw_en,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              stat_rd,
  output logic [7:0]        stat_q,
  output logic              per_flag,
  output logic              irq_flag,
  output logic              irq_n,
  output logic              sqw
);
  localparam int EFF_W = RATE_W + 1;
  localparam int IDX_W = $clog2(CNT_W);
  localparam logic [EFF_W-1:0] SLOW_SHIFT = EFF_W'(7);

  logic [CNT_W-1:0] cnt;
  logic [EFF_W-1:0] eff;
  logic [CNT_W-1:0] pmask;
  logic [IDX_W-1:0] widx;
  logic             run, pev;
  logic             pf_q, af_q, uf_q;

  assign run = (div_sel[DIV_W-1:DIV_W-2] != 2'b11);

  always_comb begin
    if (rate_sel == '0)
      eff = '0;
    else if (div_sel == DIV_SLOW && rate_sel <= RATE_W'(2))
      eff = {1'b0, rate_sel} + SLOW_SHIFT;
    else
      eff = {1'b0, rate_sel};
  end

  assign pmask = (eff == '0) ? '0 : ((CNT_W'(1) << (eff - EFF_W'(1))) - CNT_W'(1));
  assign widx  = (eff >= EFF_W'(2)) ? IDX_W'(eff - EFF_W'(2)) : '0;
  assign pev   = run && tb_tick && (eff != '0) && ((cnt & pmask) == pmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run)
      cnt <= '0;
    else if (tb_tick)
      cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= (pf_q && !stat_rd) || pev;
      af_q <= (af_q && !stat_rd) || alarm_evt;
      uf_q <= (uf_q && !stat_rd) || update_evt;
    end
  end

  assign per_flag = pf_q;
  assign irq_flag = (pf_q && pie_en) || (af_q && aie_en) || (uf_q && uie_en);
  assign irq_n    = !irq_flag;
  assign stat_q   = {irq_flag, pf_q, af_q, uf_q, 4'b0000};
  assign sqw      = sqw_en && run && (eff != '0) && cnt[widx];

  // R2
  pf_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_q) |-> $past(tb_tick));

  // R4
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !$rose(pf_q));

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!$rose(pf_q) && !sqw));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !pev && !alarm_evt && !update_evt) |=> (stat_q[6:4] == 3'b000));

  // R8
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_flag && pie_en) || (stat_q[5] && aie_en) || (stat_q[4] && uie_en)) |-> !irq_n);

  // R10
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> stat_q[5]);
endmodule

// File: tb/tb_rtc_pirq_gen.sv
module tb_rtc_pirq_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, tb_tick, pie_en, aie_en, uie_en, sqw_en;
  logic       alarm_evt, update_evt, stat_rd;
  logic [3:0] rate_sel;
  logic [2:0] div_sel;
  logic [7:0] stat_q;
  logic       per_flag, irq_flag, irq_n, sqw;

  rtc_pirq_gen dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .rate_sel(rate_sel),
    .div_sel(div_sel), .pie_en(pie_en), .aie_en(aie_en), .uie_en(uie_en),
    .sqw_en(sqw_en), .alarm_evt(alarm_evt), .update_evt(update_evt),
    .stat_rd(stat_rd), .stat_q(stat_q), .per_flag(per_flag),
    .irq_flag(irq_flag), .irq_n(irq_n), .sqw(sqw)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";
  int    tick_mode = 0;
  int    rd_period = 0;
  bit    rd_req = 0;
  int    cyc = 0;
  bit    done = 0;

  int m_cnt = 0;
  bit m_pf = 0, m_af = 0, m_uf = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int eff_code();
    if (rate_sel == 0) return 0;
    if (div_sel == 3'b010 && rate_sel <= 2) return int'(rate_sel) + 7;
    return int'(rate_sel);
  endfunction

  function automatic bit running();
    return !(div_sel == 3'b110 || div_sel == 3'b111);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      bit ev;
      int e;
      ev = 0;
      e = eff_code();
      if (stat_rd) begin m_pf = 0; m_af = 0; m_uf = 0; end
      if (!running()) m_cnt = 0;
      else if (tb_tick) begin
        if (e != 0 && ((m_cnt + 1) % (1 << (e - 1))) == 0) ev = 1;
        m_cnt = (m_cnt + 1) % 32768;
      end
      if (ev) m_pf = 1;
      if (alarm_evt) m_af = 1;
      if (update_evt) m_uf = 1;
    end
  end

  always @(posedge clk) begin
    #3;
    case (tick_mode)
      0: tb_tick <= 1'b1;
      1: tb_tick <= (cyc % 3 == 0);
      default: tb_tick <= ($urandom % 2 == 1);
    endcase
    stat_rd <= rd_req || (rd_period > 0 && (cyc % rd_period == 0));
  end

  always @(negedge clk) begin
    if (!done) begin
      int e, half;
      bit eirq, esqw;
      e = eff_code();
      half = (e >= 2) ? (1 << (e - 2)) : 1;
      eirq = (m_pf && pie_en) || (m_af && aie_en) || (m_uf && uie_en);
      esqw = sqw_en && running() && e != 0 && (((m_cnt / half) % 2) == 1);
      check(per_flag == m_pf, tag, "periodic flag", per_flag, m_pf);
      check(irq_n == !eirq && irq_flag == eirq, "R8", "irq_n", irq_n, !eirq);
      check(sqw == esqw, (tag == "R9") ? "R9" : tag, "sqw", sqw, esqw);
      check(stat_q == {eirq, m_pf, m_af, m_uf, 4'b0000}, "R6", "status byte",
            stat_q, {eirq, m_pf, m_af, m_uf, 4'b0000});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_evt(input bit al, input bit up);
    @(posedge clk); #1;
    alarm_evt = al; update_evt = up;
    @(posedge clk); #1;
    alarm_evt = 0; update_evt = 0;
  endtask

  initial begin
    rst_n = 0; tb_tick = 0; rate_sel = 0; div_sel = 0;
    pie_en = 0; aie_en = 0; uie_en = 0; sqw_en = 0;
    alarm_evt = 0; update_evt = 0; stat_rd = 0;
    rate_sel = 4'd3; sqw_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset even with a rate and square wave selected
    check(stat_q == 8'h00, "R1", "status in reset", stat_q, 0);
    check(irq_n == 1'b1, "R1", "irq_n in reset", irq_n, 1);
    check(sqw == 1'b0, "R1", "sqw in reset", sqw, 0);
    @(posedge clk); #1;
    rst_n = 1; rate_sel = 0;
    @(negedge clk);
    check(stat_q == 8'h00 && sqw == 0, "R1", "after release", stat_q, 0);

    tag = "R2"; step(1); rate_sel = 4'd3; pie_en = 1; sqw_en = 1; rd_period = 5; step(300);
    rate_sel = 4'd6; tick_mode = 2; rd_period = 41; step(2500);
    rate_sel = 4'd4; tick_mode = 1; pie_en = 0; step(400);

    tag = "R3"; div_sel = 3'b010; rate_sel = 4'd1; tick_mode = 0; pie_en = 1; rd_period = 97; step(700);
    rate_sel = 4'd2; step(900);
    div_sel = 3'b000; rate_sel = 4'd1; rd_period = 4; step(200);
    rate_sel = 4'd2; tick_mode = 1; step(200);
    div_sel = 3'b001; rate_sel = 4'd1; tick_mode = 2; step(200);

    tag = "R4"; rate_sel = 4'd0; tick_mode = 0; rd_period = 3; step(500);

    tag = "R5"; rate_sel = 4'd4; div_sel = 3'b110; step(300);
    div_sel = 3'b111; step(100);
    div_sel = 3'b000; rd_period = 0; step(40);
    rd_req = 1; step(1); rd_req = 0; step(100);

    tag = "R7"; rate_sel = 4'd1; rd_period = 3; step(100);
    rd_period = 0; rate_sel = 4'd0; rd_req = 1; step(1); rd_req = 0; step(2);
    @(negedge clk);
    check(stat_q == 8'h00, "R7", "flags after read", stat_q, 0);

    tag = "R10"; pie_en = 0; aie_en = 0; uie_en = 0;
    pulse_evt(1, 0);
    @(negedge clk);
    // R6: alarm flag alone at bit 5, no request without its enable
    check(stat_q == 8'h20, "R6", "alarm-only status", stat_q, 8'h20);
    check(irq_n == 1'b1, "R10", "no irq without enable", irq_n, 1);
    step(1); aie_en = 1; step(2);
    @(negedge clk);
    check(stat_q == 8'hA0 && irq_n == 0, "R8", "alarm with enable", stat_q, 8'hA0);
    pulse_evt(0, 1);
    step(2); uie_en = 1; aie_en = 0; step(3);
    @(negedge clk);
    check(stat_q == 8'hB0, "R10", "alarm and update flags", stat_q, 8'hB0);
    step(1); rd_req = 1; alarm_evt = 1; step(1); rd_req = 0; alarm_evt = 0; step(1);
    @(negedge clk);
    // R7: event in the read cycle survives the clear
    check(stat_q == 8'h20, "R7", "event wins over read", stat_q, 8'h20);

    tag = "R9"; aie_en = 0; rd_period = 50; rate_sel = 4'd5; sqw_en = 0; step(300);
    sqw_en = 1; step(300);
    rate_sel = 4'd15; tick_mode = 0; rd_period = 1000; pie_en = 1; step(34000);
    rate_sel = 4'd1; div_sel = 3'b000; step(50);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule